// File: doc/BRIEF.md
# Serial Port Interrupt Aggregator

This block gathers interrupt events from four serial line ports and merges them into one interrupt line for the processor. Each port raises eight kinds of event. Four are aperiodic: monitor-channel receive, monitor-channel transmit, command/indicate receive and command/indicate transmit. The other four are periodic, one for each direction of the two bearer channels B1 and B2. Every event is latched into a sticky pending bit. The interrupt line is high while any pending bit is not masked.

Software works through a small register interface that uses single-cycle read and write strobes. A summary register shows, for each aperiodic class, which ports hold a pending event of that class. Reading it has no side effect. To clear an aperiodic class, software reads the register for that class, which clears the class on every port. Each port also has a periodic status register that clears when read. Per-port configuration and interrupt-control registers set up masking in three layers: a port on/off switch, a gate for each bearer channel, and a master enable with a separate enable for each event. Masking hides pending bits from the interrupt line but never discards them.

Top module: `sirq_aggregator`

## Requirements
- R1: After reset every pending bit, configuration register and interrupt-control register is zero, `irq_o` is low, and every address reads zero.
- R2: An event pulse on `evt_i[p*8+e]` sets a pending bit. The event order is e=0 monitor rx, 1 monitor tx, 2 C/I rx, 3 C/I tx, 4 B1 tx, 5 B1 rx, 6 B2 tx, 7 B2 rx. A read of address 0 returns aperiodic class c of port p at bit c*4+p, and that read does not clear anything.
- R3: A read of address 1+c (c=0..3) returns class c of port p at bit p. The same read clears class c on all ports at the clock edge.
- R4: An event that arrives in the same cycle as the read that clears its bit stays pending.
- R5: A read of address 5+p returns port p's periodic bits in the order B1 tx, B1 rx, B2 tx, B2 rx at bits 0 to 3, and clears them.
- R6: `irq_o` is the OR of every pending bit whose event is enabled. It is combinational from the registered state.
- R7: When bit 0 (on) of port p's configuration register is 0, none of that port's eight events can drive `irq_o`.
- R8: When configuration bit 1 is 0, only the port's B1 tx and B1 rx events are masked. When bit 2 is 0, only B2 tx and B2 rx are masked.
- R9: When bit 0 (master enable) of port p's interrupt-control register is 0, none of that port's events can drive `irq_o`.
- R10: Interrupt-control bit 1+e enables event e of that port on its own.
- R11: Masking and register writes never clear pending bits. `irq_o` rises again once the mask is removed.
- R12: The configuration register of port p sits at address 9+p (3 bits). The interrupt-control register sits at 13+p (9 bits). Both are written with `wr_i` and read back with their unused bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event pulses, port p at bits p*8+7 to p*8 |
| rd_i | input | 1 | Read strobe, clears the addressed status at the edge |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Merged interrupt request |

## Verification
Single events on chosen ports and classes show whether the summary bit layout and the per-class bit layout keep port and class apart. Events that arrive in the same cycle as a clearing read, on the same port and on a different port, separate the set-over-clear priority from a plain clear. Each masking layer is tried on its own against events inside and outside its scope, so the on/off switch, the bearer-channel gates, the master enable and the per-event enables are told apart, and lifting each mask shows that nothing was lost. A long run of random sparse events, reads and writes is then compared cycle by cycle against a behavioural model.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NCLS = 4;            // aperiodic classes
    localparam int NPER = 4;            // periodic events per port
    localparam int NEVT = NCLS + NPER;  // events per port

    localparam int EV_MON_RX = 0;
    localparam int EV_MON_TX = 1;
    localparam int EV_CI_RX  = 2;
    localparam int EV_CI_TX  = 3;
    localparam int EV_B1_TX  = 4;
    localparam int EV_B1_RX  = 5;
    localparam int EV_B2_TX  = 6;
    localparam int EV_B2_RX  = 7;

    typedef struct packed {
        logic b2_en;
        logic b1_en;
        logic on;
    } port_cfg_t;

    typedef struct packed {
        logic [NEVT-1:0] evt_en;
        logic            ie;
    } port_icr_t;

    localparam int CFG_W = $bits(port_cfg_t);
    localparam int ICR_W = $bits(port_icr_t);

    // Events a port's configuration lets through
    function automatic logic [NEVT-1:0] cfg_gate(port_cfg_t c);
        logic [NEVT-1:0] g;
        g = {NEVT{c.on}};
        g[EV_B1_TX] = g[EV_B1_TX] & c.b1_en;
        g[EV_B1_RX] = g[EV_B1_RX] & c.b1_en;
        g[EV_B2_TX] = g[EV_B2_TX] & c.b2_en;
        g[EV_B2_RX] = g[EV_B2_RX] & c.b2_en;
        return g;
    endfunction

endpackage

// File: rtl/sirq_pend_bank.sv
module sirq_pend_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);

    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= (pend_o & ~clr_i) | set_i;
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/sirq_port_mask.sv
module sirq_port_mask
    import sirq_pkg::*;
(
    input  port_cfg_t       cfg_i,
    input  port_icr_t       icr_i,
    output logic [NEVT-1:0] en_o
);

    always_comb begin
        en_o = cfg_gate(cfg_i) & icr_i.evt_en & {NEVT{icr_i.ie}};
    end

endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator
    import sirq_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 5,
    parameter int DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT*NEVT-1:0] evt_i,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output logic                  irq_o
);

    localparam int A_AGG = 0;
    localparam int A_CLS = A_AGG + 1;
    localparam int A_PER = A_CLS + NCLS;
    localparam int A_CFG = A_PER + NPORT;
    localparam int A_ICR = A_CFG + NPORT;

    logic [NPORT*NEVT-1:0] pend;
    logic [NPORT*NEVT-1:0] en;
    logic [NPORT-1:0]      on_vec;
    port_cfg_t             cfg_q [NPORT];
    port_icr_t             icr_q [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_cfg_t       cfg_r;
        port_icr_t       icr_r;
        logic [NEVT-1:0] clr;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r <= '0;
                icr_r <= '0;
            end else if (wr_i) begin
                if (addr_i == AW'(A_CFG + p)) cfg_r <= port_cfg_t'(wdata_i[CFG_W-1:0]);
                if (addr_i == AW'(A_ICR + p)) icr_r <= port_icr_t'(wdata_i[ICR_W-1:0]);
            end
        end

        always_comb begin
            for (int c = 0; c < NCLS; c++)
                clr[c] = rd_i && (addr_i == AW'(A_CLS + c));
            for (int k = 0; k < NPER; k++)
                clr[NCLS+k] = rd_i && (addr_i == AW'(A_PER + p));
        end

        sirq_pend_bank #(.W(NEVT)) i_bank (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt_i[p*NEVT +: NEVT]),
            .clr_i  (clr),
            .pend_o (pend[p*NEVT +: NEVT])
        );

        sirq_port_mask i_mask (
            .cfg_i (cfg_r),
            .icr_i (icr_r),
            .en_o  (en[p*NEVT +: NEVT])
        );

        assign cfg_q[p]  = cfg_r;
        assign icr_q[p]  = icr_r;
        assign on_vec[p] = cfg_r.on;
    end

    assign irq_o = |(pend & en);

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(A_AGG)) begin
            for (int c = 0; c < NCLS; c++)
                for (int p = 0; p < NPORT; p++)
                    rdata_o[c*NPORT+p] = pend[p*NEVT+c];
        end
        for (int c = 0; c < NCLS; c++)
            if (addr_i == AW'(A_CLS + c))
                for (int p = 0; p < NPORT; p++)
                    rdata_o[p] = pend[p*NEVT+c];
        for (int p = 0; p < NPORT; p++) begin
            if (addr_i == AW'(A_PER + p)) rdata_o[NPER-1:0]  = pend[p*NEVT+NCLS +: NPER];
            if (addr_i == AW'(A_CFG + p)) rdata_o[CFG_W-1:0] = cfg_q[p];
            if (addr_i == AW'(A_ICR + p)) rdata_o[ICR_W-1:0] = icr_q[p];
        end
    end

    // R2
    summary_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == AW'(A_AGG)) |=> ((pend & $past(pend)) == $past(pend)));

    // R11
    write_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !rd_i) |=> ((pend & $past(pend)) == $past(pend)));

    // R7
    all_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (on_vec == '0) |-> !irq_o);

    // R6
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|pend));

endmodule

// File: tb/test_sirq_aggregator.sv
`timescale 1ns/1ps
module test_sirq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_cmp = 0, n_bad = 0;
    bit mp [4][8];
    int mcfg [4];
    int micr [4];

    always #2.5 clk = ~clk;

    sirq_aggregator i_sirq_aggregator (
        .clk(clk), .rst(rst), .evt_i(evt), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic int m_irq();
        for (int p = 0; p < 4; p++)
            for (int e = 0; e < 8; e++) begin
                int gate;
                gate = 1;
                if (e == 4 || e == 5) gate = (mcfg[p] >> 1) & 1;
                if (e == 6 || e == 7) gate = (mcfg[p] >> 2) & 1;
                if (mp[p][e] && (mcfg[p] & 1) && (micr[p] & 1) &&
                    ((micr[p] >> (e + 1)) & 1) && gate) return 1;
            end
        return 0;
    endfunction

    function automatic int m_rd(int a);
        int v;
        v = 0;
        if (a == 0)
            for (int c = 0; c < 4; c++)
                for (int p = 0; p < 4; p++) if (mp[p][c]) v |= 1 << (c*4 + p);
        if (a >= 1 && a <= 4)
            for (int p = 0; p < 4; p++) if (mp[p][a-1]) v |= 1 << p;
        if (a >= 5 && a <= 8)
            for (int k = 0; k < 4; k++) if (mp[a-5][4+k]) v |= 1 << k;
        if (a >= 9 && a <= 12)  v = mcfg[a-9];
        if (a >= 13 && a <= 16) v = micr[a-13];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 4; p++) begin
                mcfg[p] = 0; micr[p] = 0;
                for (int e = 0; e < 8; e++) mp[p][e] = 0;
            end
        end else begin
            if (rd) begin
                if (addr >= 1 && addr <= 4)
                    for (int p = 0; p < 4; p++) mp[p][addr-1] = 0;
                if (addr >= 5 && addr <= 8)
                    for (int k = 0; k < 4; k++) mp[addr-5][4+k] = 0;
            end
            for (int p = 0; p < 4; p++)
                for (int e = 0; e < 8; e++) if (evt[p*8+e]) mp[p][e] = 1;
            if (wr) begin
                if (addr >= 9 && addr <= 12)  mcfg[addr-9]  = wdata & 16'h7;
                if (addr >= 13 && addr <= 16) micr[addr-13] = wdata & 16'h1FF;
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare shortly after
    task automatic cyc(string tag, logic [31:0] e, logic r, logic w,
                       int a, int d);
        @(negedge clk);
        evt = e; rd = r; wr = w; addr = 5'(a); wdata = 16'(d);
        #1;
        chk({tag, " irq"}, int'(irq), m_irq());
        if (r) chk({tag, " rdata"}, int'(rdata), m_rd(a));
    endtask

    task automatic idle(string tag);
        cyc(tag, '0, 1'b0, 1'b0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 17; a++) cyc("R1", '0, 1'b1, 1'b0, a, 0);
        chk("R1 irq low", int'(irq), 0);

        // R12: configuration and interrupt control
        for (int p = 0; p < 4; p++) begin
            cyc("R12", '0, 1'b0, 1'b1, 9 + p, 16'hFFFF);
            cyc("R12", '0, 1'b0, 1'b1, 13 + p, 16'hFFFF);
        end
        cyc("R12", '0, 1'b1, 1'b0, 9, 0);
        chk("R12 cfg", int'(rdata), 7);
        cyc("R12", '0, 1'b1, 1'b0, 14, 0);
        chk("R12 icr", int'(rdata), 16'h1FF);

        // R2 / R6: monitor rx on port 2
        cyc("R2", 32'd1 << 16, 1'b0, 1'b0, 0, 0);
        idle("R6");
        chk("R6 irq set", int'(irq), 1);
        cyc("R2", '0, 1'b1, 1'b0, 0, 0);
        chk("R2 summary", int'(rdata), 4);
        cyc("R2", '0, 1'b1, 1'b0, 0, 0);
        chk("R2 summary kept", int'(rdata), 4);
        // R3: class read clears
        cyc("R3", '0, 1'b1, 1'b0, 1, 0);
        chk("R3 class", int'(rdata), 4);
        cyc("R3", '0, 1'b1, 1'b0, 1, 0);
        chk("R3 cleared", int'(rdata), 0);
        chk("R3 irq", int'(irq), 0);

        // R4: event during clearing read
        cyc("R4", 32'd1 << 11, 1'b0, 1'b0, 0, 0);
        cyc("R4", (32'd1 << 11) | (32'd1 << 27), 1'b1, 1'b0, 4, 0);
        chk("R4 old", int'(rdata), 2);
        cyc("R4", '0, 1'b1, 1'b0, 4, 0);
        chk("R4 kept", int'(rdata), 16'hA);
        cyc("R4", '0, 1'b1, 1'b0, 4, 0);
        chk("R4 gone", int'(rdata), 0);

        // R5: periodic status
        cyc("R5", 32'd1 << 7, 1'b0, 1'b0, 0, 0);
        cyc("R5", '0, 1'b1, 1'b0, 5, 0);
        chk("R5 read", int'(rdata), 8);
        cyc("R5", '0, 1'b1, 1'b0, 5, 0);
        chk("R5 cleared", int'(rdata), 0);

        // R8: B1 gate off on port 0
        cyc("R8", '0, 1'b0, 1'b1, 9, 5);
        cyc("R8", 32'd1 << 4, 1'b0, 1'b0, 0, 0);
        idle("R8");
        chk("R8 b1 masked", int'(irq), 0);
        cyc("R8", 32'd1 << 6, 1'b0, 1'b0, 0, 0);
        idle("R8");
        chk("R8 b2 open", int'(irq), 1);
        cyc("R8", '0, 1'b1, 1'b0, 5, 0);
        chk("R8 both pend", int'(rdata), 5);
        cyc("R8", '0, 1'b0, 1'b1, 9, 7);

        // R7 / R11: port 1 off
        cyc("R7", '0, 1'b0, 1'b1, 10, 6);
        cyc("R7", 32'd1 << 9, 1'b0, 1'b0, 0, 0);
        idle("R7");
        chk("R7 off", int'(irq), 0);
        cyc("R11", '0, 1'b1, 1'b0, 0, 0);
        chk("R11 still pend", int'(rdata), 16'h20);
        cyc("R11", '0, 1'b0, 1'b1, 10, 7);
        idle("R11");
        chk("R11 reassert", int'(irq), 1);
        cyc("R11", '0, 1'b1, 1'b0, 2, 0);

        // R9: master enable on port 3
        cyc("R9", '0, 1'b0, 1'b1, 16, 16'h1FE);
        cyc("R9", 32'd1 << 26, 1'b0, 1'b0, 0, 0);
        idle("R9");
        chk("R9 masked", int'(irq), 0);
        cyc("R11", '0, 1'b0, 1'b1, 16, 16'h1FF);
        idle("R11");
        chk("R11 ie back", int'(irq), 1);
        cyc("R9", '0, 1'b1, 1'b0, 3, 0);

        // R10: single event enable on port 2
        cyc("R10", '0, 1'b0, 1'b1, 15, 16'h1FB);
        cyc("R10", 32'd1 << 17, 1'b0, 1'b0, 0, 0);
        idle("R10");
        chk("R10 mon tx off", int'(irq), 0);
        cyc("R10", 32'd1 << 16, 1'b0, 1'b0, 0, 0);
        idle("R10");
        chk("R10 mon rx on", int'(irq), 1);
        cyc("R10", '0, 1'b1, 1'b0, 1, 0);
        cyc("R10", '0, 1'b1, 1'b0, 2, 0);
        cyc("R10", '0, 1'b0, 1'b1, 15, 16'h1FF);

        // R6: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] e;
            int a;
            logic r, w;
            e = $urandom & $urandom & $urandom;
            a = int'($urandom % 17);
            r = ($urandom % 3) == 0;
            w = ($urandom % 8) == 0;
            if (w && a < 9) a = 9 + int'($urandom % 8);
            cyc("R6", e, r, w, a, int'($urandom & 16'hFFFF));
        end
        idle("R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule